// File: doc/BRIEF.md
# Serial Peripheral Interface Master with Programmable Clock Divider

This block runs the controller side of a four-wire serial link with clock polarity 0. A one-cycle start pulse, given while the block is idle, latches a parallel transmit word and a divider value. The block then pulls the active-low select low and presents the most significant bit on the data-out line. It waits one full serial clock period and then produces one serial clock pulse per bit. Outgoing bits advance on falling edges, and incoming bits are captured on rising edges. After the final falling edge the data-out driver is released. Select is held low for one more low-phase width and then rises, and a one-cycle done pulse marks the received word as valid.

The serial clock is built from the divider value DIV. One divider input tick lasts two system clocks, and one serial period lasts (1 + DIV) ticks. All timing below is given in system clocks, so every phase lasts 2 x (its tick count) system clocks. For an even, nonzero DIV the high phase is one tick longer than the low phase. For an odd or zero DIV the two phases are equal.

Top module: `spim_master`

## Requirements
- R1: A synchronous active-high reset leaves select high, SCLK low, the data-out enable low, busy low and done low.
- R2: A start pulse is accepted only while busy is low. It latches the transmit word and DIV at that clock edge. A start pulse while busy is ignored and changes neither the bits sent nor the timing.
- R3: For an even, nonzero DIV, each SCLK high phase lasts DIV+2 system clocks and each low phase lasts DIV system clocks.
- R4: For an odd DIV or DIV = 0, each SCLK high phase and each low phase lasts DIV+1 system clocks.
- R5: Select goes low, and the data-out enable goes high with the most significant transmit bit on data-out, at the edge that accepts start. The first SCLK rise comes 2*(DIV+1) system clocks after that edge.
- R6: Bits leave most significant first. Data-out changes only at the edges where SCLK falls and stays stable while SCLK is high.
- R7: MISO is sampled at the system clock edge where SCLK rises. The first sampled bit becomes the most significant bit of the received word.
- R8: A transfer has exactly WORD_W rising SCLK edges. The data-out enable drops at the last falling edge. Select rises one low-phase width later, which is 2*(DIV+1)*(WORD_W+1) system clocks after start.
- R9: Busy is high from the start edge until the edge where select rises. At that edge done goes high for exactly one system clock, and the received word output holds the full word.
- R10: SCLK is low whenever select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse, one clock |
| div_i | input | DIV_W | Divider value DIV |
| tx_i | input | WORD_W | Word to send |
| rx_o | output | WORD_W | Last received word |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-clock pulse, received word valid |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_n_o | output | 1 | Slave select, active low |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Data-out driver enable (low = high impedance) |
| miso_i | input | 1 | Serial data in |

## Verification
The bench builds the block with WORD_W = 4 and DIV_W = 4. This shrinks the space enough to sweep every one of the 16 transmit words against every one of the 16 divider values. The sweep covers DIV = 0, every odd value and every even value up to 14, together with the all-zero and all-one words. In each transfer the bench measures the lead time, each high and low run, the lag and the total length. It compares these against formulas in DIV and also checks the serial bit order in both directions. A quarter of the transfers receive a stray start pulse with different data and divider mid-transfer, so the bench can confirm that it has no effect.

// File: rtl/spim_pkg.sv
package spim_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LEAD,
      ST_HIGH,
      ST_LOW
   } spim_state_e;
endpackage

// File: rtl/spim_phase_calc.sv
module spim_phase_calc #(
   parameter int DIV_W = 8,
   localparam int CNT_W = DIV_W + 2
) (
   input  logic [DIV_W-1:0] div,
   output logic [CNT_W-1:0] hi_len,
   output logic [CNT_W-1:0] lo_len,
   output logic [CNT_W-1:0] lead_len
);
   logic [CNT_W-1:0] d;
   logic             eq_split;

   assign d        = {2'b00, div};
   assign eq_split = div[0] | (div == '0);

   always_comb begin
      if (eq_split) begin
         hi_len = d + CNT_W'(1);
         lo_len = d + CNT_W'(1);
      end else begin
         hi_len = d + CNT_W'(2);
         lo_len = d;
      end
      lead_len = (d + CNT_W'(1)) << 1;
   end
endmodule

// File: rtl/spim_cnt.sv
module spim_cnt #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                 cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/spim_shreg.sv
module spim_shreg #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              advance,
   input  logic              sample,
   input  logic              miso,
   output logic              out_bit,
   output logic [WORD_W-1:0] in_word
);
   logic [WORD_W-1:0] tx_q;
   logic [WORD_W-1:0] rx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_q <= '0;
         rx_q <= '0;
      end else begin
         if (load)         tx_q <= load_word;
         else if (advance) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
         if (sample)       rx_q <= {rx_q[WORD_W-2:0], miso};
      end
   end

   assign out_bit = tx_q[WORD_W-1];
   assign in_word = rx_q;
endmodule

// File: rtl/spim_master.sv
module spim_master #(
   parameter int WORD_W = 8,
   parameter int DIV_W  = 8,
   localparam int CNT_W = DIV_W + 2,
   localparam int BIT_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic [WORD_W-1:0] tx_i,
   output logic [WORD_W-1:0] rx_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              sclk_o,
   output logic              cs_n_o,
   output logic              mosi_o,
   output logic              mosi_oe_o,
   input  logic              miso_i
);
   import spim_pkg::*;

   if (WORD_W < 2) begin : g_bad_word
      $error("WORD_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   spim_state_e       state_q;
   logic [DIV_W-1:0]  div_q;
   logic [DIV_W-1:0]  div_sel;
   logic [BIT_W-1:0]  bits_q;
   logic [WORD_W-1:0] rx_q;
   logic [WORD_W-1:0] rx_shift;
   logic              cs_n_q, sclk_q, oe_q, done_q;
   logic [CNT_W-1:0]  hi_len, lo_len, lead_len;
   logic              cnt_zero, cnt_load;
   logic [CNT_W-1:0]  cnt_val;
   logic              accept, go_high, go_low, go_end;
   logic              out_bit;

   assign accept  = (state_q == ST_IDLE) && start_i;
   assign go_high = cnt_zero && ((state_q == ST_LEAD) ||
                                 ((state_q == ST_LOW) && oe_q));
   assign go_low  = cnt_zero && (state_q == ST_HIGH);
   assign go_end  = cnt_zero && (state_q == ST_LOW) && !oe_q;
   assign div_sel = (state_q == ST_IDLE) ? div_i : div_q;

   spim_phase_calc #(.DIV_W(DIV_W)) u_phase (
      .div      (div_sel),
      .hi_len   (hi_len),
      .lo_len   (lo_len),
      .lead_len (lead_len)
   );

   always_comb begin
      cnt_load = accept | go_high | go_low;
      if (accept)       cnt_val = lead_len - CNT_W'(1);
      else if (go_high) cnt_val = hi_len - CNT_W'(1);
      else              cnt_val = lo_len - CNT_W'(1);
   end

   spim_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (cnt_load),
      .load_val (cnt_val),
      .zero     (cnt_zero)
   );

   spim_shreg #(.WORD_W(WORD_W)) u_shreg (
      .clk       (clk),
      .rst       (rst),
      .load      (accept),
      .load_word (tx_i),
      .advance   (go_low && (bits_q != '0)),
      .sample    (go_high),
      .miso      (miso_i),
      .out_bit   (out_bit),
      .in_word   (rx_shift)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         div_q   <= '0;
         bits_q  <= '0;
         rx_q    <= '0;
         cs_n_q  <= 1'b1;
         sclk_q  <= 1'b0;
         oe_q    <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            div_q   <= div_i;
            bits_q  <= BIT_W'(WORD_W - 1);
            cs_n_q  <= 1'b0;
            oe_q    <= 1'b1;
            state_q <= ST_LEAD;
         end else if (go_high) begin
            sclk_q  <= 1'b1;
            state_q <= ST_HIGH;
         end else if (go_low) begin
            sclk_q  <= 1'b0;
            state_q <= ST_LOW;
            if (bits_q == '0) oe_q   <= 1'b0;
            else              bits_q <= bits_q - BIT_W'(1);
         end else if (go_end) begin
            cs_n_q  <= 1'b1;
            done_q  <= 1'b1;
            rx_q    <= rx_shift;
            state_q <= ST_IDLE;
         end
      end
   end

   assign rx_o      = rx_q;
   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = done_q;
   assign sclk_o    = sclk_q;
   assign cs_n_o    = cs_n_q;
   assign mosi_o    = out_bit;
   assign mosi_oe_o = oe_q;

   // R10
   idle_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
      cs_n_o |-> !sclk_o);

   // R6
   mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   // R9
   busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
      !cs_n_o |-> busy_o);

   // R8
   oe_released_chk: assert property (@(posedge clk) disable iff (rst)
      cs_n_o |-> !mosi_oe_o);

   // R2
   start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
      (busy_o && start_i) |=> $stable(div_q));
endmodule

// File: tb/tb_spim_master.sv
module tb_spim_master;
   localparam int W  = 4;
   localparam int DW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start_i = 1'b0;
   logic [DW-1:0] div_i = '0;
   logic [W-1:0]  tx_i = '0;
   logic [W-1:0]  rx_o;
   logic          busy_o, done_o, sclk_o, cs_n_o, mosi_o, mosi_oe_o;
   logic          miso_i = 1'b0;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   spim_master #(.WORD_W(W), .DIV_W(DW)) dut (
      .clk(clk), .rst(rst), .start_i(start_i), .div_i(div_i), .tx_i(tx_i),
      .rx_o(rx_o), .busy_o(busy_o), .done_o(done_o), .sclk_o(sclk_o),
      .cs_n_o(cs_n_o), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o), .miso_i(miso_i)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic xfer(input int tx, input int dv, input int mw, input bit poke);
      int hi, lo, lead, tot, k, rises, run, got, mi;
      bit prev_s, prev_busy, fin;
      if (dv != 0 && dv % 2 == 0) begin hi = 2*dv/2 + 2; lo = dv; end
      else begin hi = dv + 1; lo = dv + 1; end
      lead = 2*(dv+1);
      tot  = 2*(dv+1)*(W+1);
      @(negedge clk);
      tx_i = W'(tx); div_i = DW'(dv); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      k = 0; rises = 0; run = 0; got = 0; prev_s = 1'b0; prev_busy = 1'b1; fin = 1'b0;
      mi = W - 1;
      miso_i = mw[mi];
      // R5: state right after the accepting edge
      chk(cs_n_o == 1'b0 && mosi_oe_o == 1'b1, "R5 select/enable at start",
          {cs_n_o, mosi_oe_o}, 1);
      chk(mosi_o == tx[W-1], "R5 msb on data-out", mosi_o, tx[W-1]);
      chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
      while (!fin) begin
         if (poke && k == 3) begin
            start_i = 1'b1; tx_i = ~W'(tx); div_i = DW'(dv ^ 1);
         end else begin
            start_i = 1'b0;
         end
         if (cs_n_o) begin
            fin = 1'b1;
            chk(k == tot, "R8 select rise time", k, tot);
            chk(rises == W, "R8 rising edge count", rises, W);
            chk(run == lo, "R8 lag equals low width", run, lo);
            chk(prev_busy == 1'b1 && busy_o == 1'b0, "R9 busy until select rise",
                {prev_busy, busy_o}, 2);
            chk(done_o == 1'b1, "R9 done at select rise", done_o, 1);
            chk(int'(rx_o) == (mw & ((1 << W) - 1)), "R7 received word",
                int'(rx_o), mw & ((1 << W) - 1));
            chk(got == tx, poke ? "R2 ignored start, bits sent" : "R6 bits sent msb first",
                got, tx);
         end else begin
            if (sclk_o && !prev_s) begin
               rises++;
               if (rises == 1) chk(k == lead, "R5 lead time", k, lead);
               else chk(run == lo, (dv != 0 && dv % 2 == 0) ? "R3 low width" : "R4 low width",
                        run, lo);
               chk(mosi_oe_o == 1'b1, "R6 enable during bits", mosi_oe_o, 1);
               got = (got << 1) | int'(mosi_o);
               run = 1;
            end else if (!sclk_o && prev_s) begin
               chk(run == hi, (dv != 0 && dv % 2 == 0) ? "R3 high width" : "R4 high width",
                   run, hi);
               if (rises == W) chk(mosi_oe_o == 1'b0, "R8 enable drop at last fall",
                                   mosi_oe_o, 0);
               if (mi > 0) begin mi--; miso_i = mw[mi]; end
               run = 1;
            end else begin
               run++;
            end
            prev_s    = sclk_o;
            prev_busy = busy_o;
            if (k > 5000) begin
               chk(1'b0, "R8 transfer never ended", k, tot);
               fin = 1'b1;
            end else begin
               @(negedge clk);
               k++;
            end
         end
      end
      start_i = 1'b0;
      @(negedge clk);
      chk(done_o == 1'b0, "R9 done one cycle", done_o, 0);
      chk(sclk_o == 1'b0 && cs_n_o == 1'b1, "R10 idle after transfer",
          {sclk_o, cs_n_o}, 1);
   endtask

   initial begin
      #2_000_000;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1
      chk(cs_n_o == 1'b1, "R1 select high", cs_n_o, 1);
      chk(sclk_o == 1'b0, "R1 sclk low", sclk_o, 0);
      chk(mosi_oe_o == 1'b0, "R1 data-out released", mosi_oe_o, 0);
      chk(busy_o == 1'b0 && done_o == 1'b0, "R1 busy/done low", {busy_o, done_o}, 0);
      for (int dv = 0; dv < (1 << DW); dv++) begin
         for (int tx = 0; tx < (1 << W); tx++) begin
            xfer(tx, dv, (tx*5 + dv*3 + 6) & ((1 << W) - 1), (tx % 4) == 1);
         end
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule